// File: doc/BRIEF.md
# Restart Cause Flag Keeper

This block holds seven sticky status flags that firmware inspects after a restart to learn what caused it. It also produces the program-counter value the core loads after each event. Eight single-cycle event strobes come in: power-on, brown-out, software reset instruction, external master-clear, watchdog expiry, stack overflow, stack underflow and interrupt wake-up. Each event changes only its own subset of flags. The outcome can depend on the power mode in force when the event arrives, and on the stack-reset enable and the two interrupt priority enables.

An event is either a true restart or a resume. A true restart sends the core to address zero. A resume continues at the current PC plus two, or at an interrupt vector. The block raises a one-cycle pulse that tells which kind of event occurred, so that downstream logic can skip reinitialisation after a wake-up. Firmware can overwrite the flags through a simple write port.

Top module: `rstcause_tracker`

## Requirements
- R1: Flag bit positions are [0] softRst (cleared by the reset instruction), [1] noWdog (cleared by a watchdog expiry), [2] awake (cleared on sleep-type wake-ups), [3] pwrOn, [4] brown, [5] stkHi and [6] stkLo. While rstN is low the flags read 7'b0000111, both pulses are 0 and nextPc is 0.
- R2: Power-on forces the flags to 7'b0000111 and is a restart to PC 0.
- R3: Brown-out sets bits 0, 1 and 2, clears bit 4 and keeps bits 3, 5 and 6. It is a restart to PC 0.
- R4: The software reset instruction clears bit 0 only and is a restart to PC 0.
- R5: Master-clear is always a restart to PC 0. The power mode is encoded 0 full, 1 managed run, 2 idle, 3 sleep. In full mode master-clear changes no flag. In run mode it sets bit 1. In idle or sleep it sets bit 1 and clears bit 2.
- R6: A watchdog expiry in full or run mode clears bit 1 and is a restart to PC 0.
- R7: A watchdog expiry in idle or sleep mode clears bits 1 and 2 and is a resume at curPc+2, which wraps modulo 2^PC_W.
- R8: An interrupt wake-up in run, idle or sleep mode clears bit 2 and is a resume. With both priority enables at 0 the resume address is curPc+2. With either enable set it is 0x0008 when wakeHiPri is 1 and 0x0018 when it is 0. In full mode the wake-up strobe has no effect.
- R9: Stack overflow sets bit 5 and stack underflow sets bit 6. Either one is a restart to PC 0 only when stackRstEn is 1. Otherwise it raises no pulse.
- R10: When several strobes arrive together, only the highest-priority one acts. The order, highest first, is power-on, brown-out, master-clear, watchdog, overflow, underflow, reset instruction, interrupt wake-up.
- R11: With no effective event, wrEn loads wrData into the flags at the next edge. An effective event in the same cycle overrides the write entirely.
- R12: restartPulse and resumePulse are high for exactly the one cycle after the event edge, are never both high, and stay low after a cycle with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPowerOn | input | 1 | Power-on event strobe |
| evtBrownOut | input | 1 | Brown-out event strobe |
| evtSwReset | input | 1 | Reset instruction strobe |
| evtMasterClr | input | 1 | External master-clear strobe |
| evtWdog | input | 1 | Watchdog expiry strobe |
| evtStackOvf | input | 1 | Stack overflow strobe |
| evtStackUnf | input | 1 | Stack underflow strobe |
| evtIrqWake | input | 1 | Interrupt wake-up strobe |
| pwrMode | input | 2 | Power mode: 0 full, 1 run, 2 idle, 3 sleep |
| stackRstEn | input | 1 | Stack faults force a restart |
| irqHiEn | input | 1 | High-priority interrupt enable |
| irqLoEn | input | 1 | Low-priority interrupt enable |
| wakeHiPri | input | 1 | Waking interrupt is high priority |
| curPc | input | PC_W | Current program counter |
| wrEn | input | 1 | Firmware flag write enable |
| wrData | input | 7 | Firmware flag write data |
| flags | output | 7 | Sticky status flags |
| restartPulse | output | 1 | One-cycle true-restart marker |
| resumePulse | output | 1 | One-cycle wake-up resume marker |
| nextPc | output | PC_W | PC to load, valid with either pulse |

## Verification
Every result is due one clock edge after the stimulus is presented. This holds for the flags, for either pulse and for nextPc, because the decode feeds registers directly. The driver applies one stimulus per cycle on the falling edge and queues the expected outcome. The monitor then pops one item 2 ns after each following rising edge, so each comparison lands exactly in the cycle the registered result first appears. nextPc is compared only in cycles where a pulse marks it valid.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int FLAG_W = 7;
  localparam int F_SOFT   = 0;
  localparam int F_NOWDOG = 1;
  localparam int F_AWAKE  = 2;
  localparam int F_PWRON  = 3;
  localparam int F_BROWN  = 4;
  localparam int F_STKHI  = 5;
  localparam int F_STKLO  = 6;
  localparam int NUM_EVT  = 8;

  localparam logic [FLAG_W-1:0] FLAGS_POWERON = 7'b0000111;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_IDLE  = 2'd2,
    MODE_SLEEP = 2'd3
  } pwrMode_e;

  typedef enum logic [1:0] {
    PC_ZERO   = 2'd0,
    PC_PLUS2  = 2'd1,
    PC_VEC_HI = 2'd2,
    PC_VEC_LO = 2'd3
  } pcSel_e;

  // priority slots, highest first
  typedef enum int {
    SLOT_PWRON = 0, SLOT_BROWN = 1, SLOT_MCLR = 2, SLOT_WDOG = 3,
    SLOT_OVF = 4, SLOT_UNF = 5, SLOT_SWRST = 6, SLOT_IRQ = 7
  } evtSlot_e;

  typedef struct packed {
    logic              hit;
    logic              doRestart;
    logic              doResume;
    pcSel_e            pcSel;
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
  } ctrlStrobes_t;
endpackage

// File: rtl/rstcause_ctrl.sv
module rstcause_ctrl
  import rstcause_pkg::*;
(
  input  logic         evtPowerOn,
  input  logic         evtBrownOut,
  input  logic         evtSwReset,
  input  logic         evtMasterClr,
  input  logic         evtWdog,
  input  logic         evtStackOvf,
  input  logic         evtStackUnf,
  input  logic         evtIrqWake,
  input  logic [1:0]   pwrMode,
  input  logic         stackRstEn,
  input  logic         irqHiEn,
  input  logic         irqLoEn,
  input  logic         wakeHiPri,
  output ctrlStrobes_t strb
);
  pwrMode_e mode;
  logic lowPower;
  logic [NUM_EVT-1:0] evtVec;
  logic [NUM_EVT-1:0] grant;
  logic [NUM_EVT-1:0] higherSeen;

  assign mode     = pwrMode_e'(pwrMode);
  assign lowPower = (mode == MODE_IDLE) || (mode == MODE_SLEEP);

  always_comb begin
    evtVec              = '0;
    evtVec[SLOT_PWRON]  = evtPowerOn;
    evtVec[SLOT_BROWN]  = evtBrownOut;
    evtVec[SLOT_MCLR]   = evtMasterClr;
    evtVec[SLOT_WDOG]   = evtWdog;
    evtVec[SLOT_OVF]    = evtStackOvf;
    evtVec[SLOT_UNF]    = evtStackUnf;
    evtVec[SLOT_SWRST]  = evtSwReset;
    evtVec[SLOT_IRQ]    = evtIrqWake && (mode != MODE_FULL);
  end

  // fixed-priority grant: one slot per stage
  genvar g;
  generate
    for (g = 0; g < NUM_EVT; g++) begin : gPrio
      if (g == 0) begin : gFirst
        assign higherSeen[g] = 1'b0;
      end else begin : gRest
        assign higherSeen[g] = higherSeen[g-1] | evtVec[g-1];
      end
      assign grant[g] = evtVec[g] & ~higherSeen[g];
    end
  endgenerate

  always_comb begin
    strb           = '0;
    strb.pcSel     = PC_ZERO;
    strb.hit       = |grant;
    if (grant[SLOT_PWRON]) begin
      strb.setMask   = FLAGS_POWERON;
      strb.clrMask   = ~FLAGS_POWERON;
      strb.doRestart = 1'b1;
    end else if (grant[SLOT_BROWN]) begin
      strb.setMask[F_SOFT]   = 1'b1;
      strb.setMask[F_NOWDOG] = 1'b1;
      strb.setMask[F_AWAKE]  = 1'b1;
      strb.clrMask[F_BROWN]  = 1'b1;
      strb.doRestart         = 1'b1;
    end else if (grant[SLOT_MCLR]) begin
      strb.doRestart = 1'b1;
      if (mode != MODE_FULL) strb.setMask[F_NOWDOG] = 1'b1;
      if (lowPower)          strb.clrMask[F_AWAKE]  = 1'b1;
    end else if (grant[SLOT_WDOG]) begin
      strb.clrMask[F_NOWDOG] = 1'b1;
      if (lowPower) begin
        strb.clrMask[F_AWAKE] = 1'b1;
        strb.doResume         = 1'b1;
        strb.pcSel            = PC_PLUS2;
      end else begin
        strb.doRestart = 1'b1;
      end
    end else if (grant[SLOT_OVF]) begin
      strb.setMask[F_STKHI] = 1'b1;
      strb.doRestart        = stackRstEn;
    end else if (grant[SLOT_UNF]) begin
      strb.setMask[F_STKLO] = 1'b1;
      strb.doRestart        = stackRstEn;
    end else if (grant[SLOT_SWRST]) begin
      strb.clrMask[F_SOFT] = 1'b1;
      strb.doRestart       = 1'b1;
    end else if (grant[SLOT_IRQ]) begin
      strb.clrMask[F_AWAKE] = 1'b1;
      strb.doResume         = 1'b1;
      if (irqHiEn || irqLoEn) strb.pcSel = wakeHiPri ? PC_VEC_HI : PC_VEC_LO;
      else                    strb.pcSel = PC_PLUS2;
    end
  end
endmodule

// File: rtl/rstcause_dp.sv
module rstcause_dp
  import rstcause_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int VEC_HI = 8,
  parameter int VEC_LO = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] wrData,
  input  logic [PC_W-1:0]   curPc,
  output logic [FLAG_W-1:0] flags,
  output logic              restartPulse,
  output logic              resumePulse,
  output logic [PC_W-1:0]   nextPc
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(2);
  localparam logic [PC_W-1:0] PC_HI   = PC_W'(VEC_HI);
  localparam logic [PC_W-1:0] PC_LO   = PC_W'(VEC_LO);

  logic [FLAG_W-1:0] flagsQ;
  logic [PC_W-1:0]   pcCalc;
  logic [PC_W-1:0]   nextPcQ;
  logic              restartQ, resumeQ;

  always_comb begin
    unique case (strb.pcSel)
      PC_PLUS2:  pcCalc = curPc + PC_STEP;
      PC_VEC_HI: pcCalc = PC_HI;
      PC_VEC_LO: pcCalc = PC_LO;
      default:   pcCalc = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ   <= FLAGS_POWERON;
      restartQ <= 1'b0;
      resumeQ  <= 1'b0;
      nextPcQ  <= '0;
    end else begin
      if (strb.hit)  flagsQ <= (flagsQ & ~strb.clrMask) | strb.setMask;
      else if (wrEn) flagsQ <= wrData;
      restartQ <= strb.hit & strb.doRestart;
      resumeQ  <= strb.hit & strb.doResume;
      if (strb.hit && (strb.doRestart || strb.doResume)) nextPcQ <= pcCalc;
    end
  end

  assign flags        = flagsQ;
  assign restartPulse = restartQ;
  assign resumePulse  = resumeQ;
  assign nextPc       = nextPcQ;
endmodule

// File: rtl/rstcause_tracker.sv
module rstcause_tracker
  import rstcause_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int VEC_HI = 8,
  parameter int VEC_LO = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evtPowerOn,
  input  logic            evtBrownOut,
  input  logic            evtSwReset,
  input  logic            evtMasterClr,
  input  logic            evtWdog,
  input  logic            evtStackOvf,
  input  logic            evtStackUnf,
  input  logic            evtIrqWake,
  input  logic [1:0]      pwrMode,
  input  logic            stackRstEn,
  input  logic            irqHiEn,
  input  logic            irqLoEn,
  input  logic            wakeHiPri,
  input  logic [PC_W-1:0] curPc,
  input  logic            wrEn,
  input  logic [6:0]      wrData,
  output logic [6:0]      flags,
  output logic            restartPulse,
  output logic            resumePulse,
  output logic [PC_W-1:0] nextPc
);
  ctrlStrobes_t strb;

  rstcause_ctrl u_ctrl (
    .evtPowerOn  (evtPowerOn),
    .evtBrownOut (evtBrownOut),
    .evtSwReset  (evtSwReset),
    .evtMasterClr(evtMasterClr),
    .evtWdog     (evtWdog),
    .evtStackOvf (evtStackOvf),
    .evtStackUnf (evtStackUnf),
    .evtIrqWake  (evtIrqWake),
    .pwrMode     (pwrMode),
    .stackRstEn  (stackRstEn),
    .irqHiEn     (irqHiEn),
    .irqLoEn     (irqLoEn),
    .wakeHiPri   (wakeHiPri),
    .strb        (strb)
  );

  rstcause_dp #(.PC_W(PC_W), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .curPc       (curPc),
    .flags       (flags),
    .restartPulse(restartPulse),
    .resumePulse (resumePulse),
    .nextPc      (nextPc)
  );
endmodule

// File: rtl/rstcause_checker.sv
module rstcause_checker #(
  parameter int PC_W = 21
) (
  input logic            clk,
  input logic            rstN,
  input logic            evtPowerOn,
  input logic            evtBrownOut,
  input logic            evtSwReset,
  input logic            evtMasterClr,
  input logic            evtWdog,
  input logic            evtStackOvf,
  input logic            evtStackUnf,
  input logic            evtIrqWake,
  input logic [1:0]      pwrMode,
  input logic            stackRstEn,
  input logic [PC_W-1:0] curPc,
  input logic            wrEn,
  input logic [6:0]      wrData,
  input logic [6:0]      flags,
  input logic            restartPulse,
  input logic            resumePulse,
  input logic [PC_W-1:0] nextPc
);
  logic anyEvt;
  logic [7:0] evtBits;
  assign evtBits = {evtPowerOn, evtBrownOut, evtSwReset, evtMasterClr,
                    evtWdog, evtStackOvf, evtStackUnf, evtIrqWake};
  assign anyEvt  = |evtBits;

  // R2
  a_r2_poweron: assert property (@(posedge clk) disable iff (!rstN)
    evtPowerOn |=> (flags == 7'b0000111) && restartPulse && (nextPc == '0));

  // R4
  a_r4_swreset: assert property (@(posedge clk) disable iff (!rstN)
    (evtSwReset && $countones(evtBits) == 1) |=> !flags[0] && restartPulse && !resumePulse);

  // R7
  a_r7_wdog_wake: assert property (@(posedge clk) disable iff (!rstN)
    (evtWdog && $countones(evtBits) == 1 && pwrMode[1])
      |=> resumePulse && !flags[1] && !flags[2] && (nextPc == PC_W'($past(curPc) + 2)));

  // R9
  a_r9_unf_noreset: assert property (@(posedge clk) disable iff (!rstN)
    (evtStackUnf && $countones(evtBits) == 1 && !stackRstEn)
      |=> flags[6] && !restartPulse && !resumePulse);

  // R11
  a_r11_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !anyEvt) |=> flags == $past(wrData));

  // R11 / R12
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!anyEvt && !wrEn) |=> $stable(flags) && !restartPulse && !resumePulse);

  // R12
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({restartPulse, resumePulse}));
endmodule

bind rstcause_tracker rstcause_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .evtPowerOn(evtPowerOn), .evtBrownOut(evtBrownOut),
  .evtSwReset(evtSwReset), .evtMasterClr(evtMasterClr), .evtWdog(evtWdog),
  .evtStackOvf(evtStackOvf), .evtStackUnf(evtStackUnf), .evtIrqWake(evtIrqWake),
  .pwrMode(pwrMode), .stackRstEn(stackRstEn), .curPc(curPc), .wrEn(wrEn),
  .wrData(wrData), .flags(flags), .restartPulse(restartPulse),
  .resumePulse(resumePulse), .nextPc(nextPc)
);

// File: tb/rstcause_tracker_bench.sv
module rstcause_tracker_bench;
  localparam int PC_W = 21;

  typedef struct {
    logic [6:0]      flags;
    logic            rst;
    logic            res;
    logic [PC_W-1:0] pc;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtPowerOn = 0, evtBrownOut = 0, evtSwReset = 0, evtMasterClr = 0;
  logic evtWdog = 0, evtStackOvf = 0, evtStackUnf = 0, evtIrqWake = 0;
  logic [1:0] pwrMode = 2'd0;
  logic stackRstEn = 0, irqHiEn = 0, irqLoEn = 0, wakeHiPri = 0;
  logic [PC_W-1:0] curPc = '0;
  logic wrEn = 0;
  logic [6:0] wrData = '0;
  logic [6:0] flags;
  logic restartPulse, resumePulse;
  logic [PC_W-1:0] nextPc;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;
  exp_t expQ[$];
  logic [6:0] mFlags = 7'b0000111;

  always #5 clk = ~clk;

  rstcause_tracker #(.PC_W(PC_W)) u_rstcause_tracker (
    .clk(clk), .rstN(rstN), .evtPowerOn(evtPowerOn), .evtBrownOut(evtBrownOut),
    .evtSwReset(evtSwReset), .evtMasterClr(evtMasterClr), .evtWdog(evtWdog),
    .evtStackOvf(evtStackOvf), .evtStackUnf(evtStackUnf), .evtIrqWake(evtIrqWake),
    .pwrMode(pwrMode), .stackRstEn(stackRstEn), .irqHiEn(irqHiEn), .irqLoEn(irqLoEn),
    .wakeHiPri(wakeHiPri), .curPc(curPc), .wrEn(wrEn), .wrData(wrData),
    .flags(flags), .restartPulse(restartPulse), .resumePulse(resumePulse), .nextPc(nextPc)
  );

  // ev bits: 0 power-on, 1 brown-out, 2 reset instr, 3 master-clear,
  //          4 watchdog, 5 overflow, 6 underflow, 7 irq wake
  function automatic exp_t predict(input logic [6:0] f, input logic [7:0] ev,
      input logic [1:0] mode, input logic sEn, input logic hEn, input logic lEn,
      input logic hPri, input logic [PC_W-1:0] pc, input logic we, input logic [6:0] wd);
    exp_t e;
    e.flags = f; e.rst = 0; e.res = 0; e.pc = '0; e.tag = "";
    if (ev[0]) begin
      e.flags = 7'b0000111; e.rst = 1;
    end else if (ev[1]) begin
      e.flags = (f | 7'b0000111) & 7'b1101111; e.rst = 1;
    end else if (ev[3]) begin
      e.rst = 1;
      if (mode != 2'd0) e.flags[1] = 1'b1;
      if (mode >= 2'd2) e.flags[2] = 1'b0;
    end else if (ev[4]) begin
      e.flags[1] = 1'b0;
      if (mode >= 2'd2) begin e.flags[2] = 1'b0; e.res = 1; e.pc = pc + 2; end
      else e.rst = 1;
    end else if (ev[5]) begin
      e.flags[5] = 1'b1; e.rst = sEn;
    end else if (ev[6]) begin
      e.flags[6] = 1'b1; e.rst = sEn;
    end else if (ev[2]) begin
      e.flags[0] = 1'b0; e.rst = 1;
    end else if (ev[7] && mode != 2'd0) begin
      e.flags[2] = 1'b0; e.res = 1;
      if (hEn || lEn) e.pc = hPri ? PC_W'(8) : PC_W'(24);
      else e.pc = pc + 2;
    end else if (we) begin
      e.flags = wd;
    end
    return e;
  endfunction

  task automatic step(input logic [7:0] ev, input logic [1:0] mode, input logic sEn,
      input logic hEn, input logic lEn, input logic hPri, input logic [PC_W-1:0] pc,
      input logic we, input logic [6:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    {evtIrqWake, evtStackUnf, evtStackOvf, evtWdog, evtMasterClr, evtSwReset,
     evtBrownOut, evtPowerOn} = ev;
    pwrMode = mode; stackRstEn = sEn; irqHiEn = hEn; irqLoEn = lEn;
    wakeHiPri = hPri; curPc = pc; wrEn = we; wrData = wd;
    e = predict(mFlags, ev, mode, sEn, hEn, lEn, hPri, pc, we, wd);
    e.tag = tag;
    mFlags = e.flags;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(8'h00, 2'd0, 0, 0, 0, 0, '0, 0, '0, tag);
  endtask

  task automatic wr(input logic [6:0] d, input string tag);
    step(8'h00, 2'd0, 0, 0, 0, 0, '0, 1, d, tag);
  endtask

  // monitor: results are due one edge after the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        vectors++;
        if (flags !== e.flags || restartPulse !== e.rst || resumePulse !== e.res ||
            ((e.rst || e.res) && nextPc !== e.pc)) begin
          errors++;
          $display("FAIL %s: flags=%b rst=%b res=%b pc=%h expected flags=%b rst=%b res=%b pc=%h",
                   e.tag, flags, restartPulse, resumePulse, nextPc,
                   e.flags, e.rst, e.res, e.pc);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state checked while reset is held
    vectors++;
    if (flags !== 7'b0000111 || restartPulse !== 0 || resumePulse !== 0 || nextPc !== '0) begin
      errors++;
      $display("FAIL R1: flags=%b rst=%b res=%b pc=%h expected 0000111 0 0 0",
               flags, restartPulse, resumePulse, nextPc);
    end
    rstN = 1'b1;
    idle("R1 idle after reset");
    wr(7'b1111000, "R11 write");
    step(8'h01, 2'd0, 0, 0, 0, 0, 21'h100, 0, '0, "R2 power-on");
    wr(7'b1111111, "R11 write all ones");
    step(8'h02, 2'd1, 0, 0, 0, 0, 21'h100, 0, '0, "R3 brown-out");
    wr(7'b1101000, "R11 write");
    step(8'h02, 2'd0, 0, 0, 0, 0, 21'h100, 0, '0, "R3 brown-out sets low bits");
    step(8'h04, 2'd0, 0, 0, 0, 0, 21'h100, 0, '0, "R4 reset instruction");
    step(8'h08, 2'd0, 0, 0, 0, 0, 21'h100, 0, '0, "R5 master-clear full");
    wr(7'b0000000, "R11 write zero");
    step(8'h08, 2'd1, 0, 0, 0, 0, 21'h100, 0, '0, "R5 master-clear run");
    wr(7'b0000110, "R11 write");
    step(8'h08, 2'd3, 0, 0, 0, 0, 21'h100, 0, '0, "R5 master-clear sleep");
    wr(7'b0000110, "R11 write");
    step(8'h08, 2'd2, 0, 0, 0, 0, 21'h100, 0, '0, "R5 master-clear idle");
    wr(7'b0000111, "R11 write");
    step(8'h10, 2'd0, 0, 0, 0, 0, 21'h200, 0, '0, "R6 watchdog full");
    wr(7'b0000111, "R11 write");
    step(8'h10, 2'd1, 0, 0, 0, 0, 21'h200, 0, '0, "R6 watchdog run");
    wr(7'b0000111, "R11 write");
    step(8'h10, 2'd3, 0, 0, 0, 0, 21'h200, 0, '0, "R7 watchdog sleep");
    wr(7'b0000111, "R11 write");
    step(8'h10, 2'd2, 0, 0, 0, 0, {PC_W{1'b1}}, 0, '0, "R7 watchdog idle wrap");
    wr(7'b0000111, "R11 write");
    step(8'h80, 2'd3, 0, 0, 0, 0, 21'h340, 0, '0, "R8 irq wake plus two");
    wr(7'b0000111, "R11 write");
    step(8'h80, 2'd2, 0, 1, 0, 1, 21'h340, 0, '0, "R8 irq wake high vector");
    wr(7'b0000111, "R11 write");
    step(8'h80, 2'd1, 0, 0, 1, 0, 21'h340, 0, '0, "R8 irq wake low vector");
    wr(7'b0000111, "R11 write");
    step(8'h80, 2'd0, 0, 1, 1, 1, 21'h340, 0, '0, "R8 irq wake ignored in full");
    step(8'h20, 2'd0, 1, 0, 0, 0, 21'h10, 0, '0, "R9 overflow restart");
    wr(7'b0000111, "R11 write");
    step(8'h20, 2'd0, 0, 0, 0, 0, 21'h10, 0, '0, "R9 overflow no restart");
    step(8'h40, 2'd0, 0, 0, 0, 0, 21'h10, 0, '0, "R9 underflow no restart");
    wr(7'b0000111, "R11 write");
    step(8'h40, 2'd0, 1, 0, 0, 0, 21'h10, 0, '0, "R9 underflow restart");
    wr(7'b1111000, "R11 write");
    step(8'h05, 2'd0, 0, 0, 0, 0, 21'h10, 0, '0, "R10 power-on over reset instr");
    wr(7'b0000111, "R11 write");
    step(8'h18, 2'd2, 0, 0, 0, 0, 21'h10, 0, '0, "R10 master-clear over watchdog");
    wr(7'b0000111, "R11 write");
    step(8'h30, 2'd3, 1, 0, 0, 0, 21'h10, 0, '0, "R10 watchdog over stack");
    wr(7'b0000111, "R11 write");
    step(8'h64, 2'd0, 0, 0, 0, 0, 21'h10, 0, '0, "R10 overflow over underflow and instr");
    wr(7'b0000111, "R11 write");
    step(8'h84, 2'd3, 0, 0, 0, 0, 21'h10, 0, '0, "R10 reset instr over irq wake");
    step(8'h04, 2'd0, 0, 0, 0, 0, 21'h10, 1, 7'b1010101, "R11 event overrides write");
    idle("R12 pulse drops after one cycle");
    idle("R12 quiet");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d results never observed, expected 0", expQ.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule